// File: doc/BRIEF.md
# Register Rename Stage with Mapping Table and Free List

This block renames the destination registers of an instruction stream onto a physical register file that is larger than the architectural one. A mapping table keeps, for every logical register, the physical tag that holds its newest value. A circular queue holds the physical tags that are not in use.

Each cycle the stage accepts at most one instruction. The instruction names two logical sources and, optionally, one logical destination. The stage returns the physical tags of both sources. When a destination is present, it also returns a freshly allocated destination tag and the tag that the destination mapped to before this instruction. The pipeline keeps that displaced tag and hands it back through the release port when the instruction retires. A release returns one tag per cycle to the queue.

If no free tag is left, the stage deasserts ready and changes no state until a tag is released. Renaming gives every write its own physical register, so write-after-read and write-after-write conflicts between instructions disappear.

Top module: `reg_renamer`

## Requirements
- R1: After reset, logical register i maps to physical tag i for every i in 0..N_LOG-1.
- R2: `ren_ready_o` is 1 exactly when the free queue holds at least one tag. After reset the queue holds N_PHYS-N_LOG tags.
- R3: After reset, successive allocations hand out tags N_LOG, N_LOG+1, ..., N_PHYS-1 in ascending order.
- R4: A rename with `dst_en_i`=1 and handshake (`ren_valid_i`=1 and `ren_ready_o`=1) maps the destination to `dst_phys_o` from the next cycle on. Later source lookups of that logical register return the new tag.
- R5: `old_phys_o` equals the tag that the destination register mapped to before the rename.
- R6: Source lookups use the mapping from before the same instruction's destination update. A source equal to the destination returns the old tag.
- R7: While `ren_ready_o`=0, a request with `ren_valid_i`=1 changes no mapping and consumes no tag.
- R8: Released tags return to the tail of the queue. They are allocated again in release order, after all tags already queued.
- R9: A handshaken rename with `dst_en_i`=0 consumes no tag and changes no mapping.
- R10: A newly allocated destination tag always differs from the displaced tag. Two writes to the same logical register receive different tags.
- R11: An allocation and a release in the same cycle leave the queue occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | 1 | Rename request present |
| ren_ready_o | output | 1 | A free tag is available; request accepted when high |
| src0_log_i | input | $clog2(N_LOG) | First logical source |
| src1_log_i | input | $clog2(N_LOG) | Second logical source |
| dst_en_i | input | 1 | Instruction writes a destination |
| dst_log_i | input | $clog2(N_LOG) | Logical destination |
| src0_phys_o | output | $clog2(N_PHYS) | Physical tag of first source |
| src1_phys_o | output | $clog2(N_PHYS) | Physical tag of second source |
| dst_phys_o | output | $clog2(N_PHYS) | Newly allocated destination tag |
| old_phys_o | output | $clog2(N_PHYS) | Tag displaced from the destination |
| rel_valid_i | input | 1 | Release a tag to the free queue |
| rel_phys_i | input | $clog2(N_PHYS) | Tag being released |

## Verification
The bench builds the block with 8 logical and 16 physical registers. This size lets it walk every logical register through its reset mapping, drain the whole eight-entry queue to the stall, and refill the queue in a chosen order. A long pseudo-random phase then mixes renames, no-destination requests and deferred releases. A reference map and queue kept in the bench predict each cycle's tags, which brings full wrap-around of the queue pointers and same-cycle allocate-and-release within reach.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_N_LOG  = 8;
  localparam int unsigned DEF_N_PHYS = 16;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned N_LOG  = rn_pkg::DEF_N_LOG,
  parameter int unsigned N_PHYS = rn_pkg::DEF_N_PHYS,
  parameter int unsigned N_RD   = 3,
  localparam int unsigned LOG_W  = $clog2(N_LOG),
  localparam int unsigned PHYS_W = $clog2(N_PHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOG_W-1:0]  rd_addr_i [N_RD],
  output logic [PHYS_W-1:0] rd_data_o [N_RD],
  input  logic              wr_en_i,
  input  logic [LOG_W-1:0]  wr_addr_i,
  input  logic [PHYS_W-1:0] wr_data_i
);
  logic [PHYS_W-1:0] tab_q [N_LOG];

  // reads see the table before this cycle's write
  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_data_o[r] = tab_q[rd_addr_i[r]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LOG; i++) tab_q[i] <= PHYS_W'(i);
    end else if (wr_en_i) begin
      tab_q[wr_addr_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned N_LOG  = rn_pkg::DEF_N_LOG,
  parameter int unsigned N_PHYS = rn_pkg::DEF_N_PHYS,
  localparam int unsigned PHYS_W = $clog2(N_PHYS),
  localparam int unsigned FREE_N = N_PHYS - N_LOG,
  localparam int unsigned PTR_W  = (FREE_N > 1) ? $clog2(FREE_N) : 1,
  localparam int unsigned CNT_W  = $clog2(FREE_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [PHYS_W-1:0] push_tag_i,
  output logic [PHYS_W-1:0] head_tag_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [PHYS_W-1:0] mem_q [FREE_N];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FREE_N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt_q == CNT_W'(FREE_N));
  assign empty_o    = (cnt_q == '0);
  assign do_pop     = pop_i && !empty_o;
  assign do_push    = push_i && (!full || do_pop);
  assign head_tag_o = mem_q[head_q];
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FREE_N; i++) mem_q[i] <= PHYS_W'(N_LOG + i);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CNT_W'(FREE_N);
    end else begin
      if (do_push) begin
        mem_q[tail_q] <= push_tag_i;
        tail_q        <= ptr_inc(tail_q);
      end
      if (do_pop) head_q <= ptr_inc(head_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int unsigned N_LOG  = rn_pkg::DEF_N_LOG,
  parameter int unsigned N_PHYS = rn_pkg::DEF_N_PHYS,
  localparam int unsigned LOG_W  = $clog2(N_LOG),
  localparam int unsigned PHYS_W = $clog2(N_PHYS),
  localparam int unsigned CNT_W  = $clog2(N_PHYS - N_LOG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_valid_i,
  output logic              ren_ready_o,
  input  logic [LOG_W-1:0]  src0_log_i,
  input  logic [LOG_W-1:0]  src1_log_i,
  input  logic              dst_en_i,
  input  logic [LOG_W-1:0]  dst_log_i,
  output logic [PHYS_W-1:0] src0_phys_o,
  output logic [PHYS_W-1:0] src1_phys_o,
  output logic [PHYS_W-1:0] dst_phys_o,
  output logic [PHYS_W-1:0] old_phys_o,
  input  logic              rel_valid_i,
  input  logic [PHYS_W-1:0] rel_phys_i
);
  logic [LOG_W-1:0]  rd_addr [3];
  logic [PHYS_W-1:0] rd_data [3];
  logic              fl_empty, alloc;
  logic [PHYS_W-1:0] fl_head;
  logic [CNT_W-1:0]  fl_count;

  assign ren_ready_o = !fl_empty;
  assign alloc       = ren_valid_i && ren_ready_o && dst_en_i;

  assign rd_addr[0] = src0_log_i;
  assign rd_addr[1] = src1_log_i;
  assign rd_addr[2] = dst_log_i;

  rn_map_table #(.N_LOG(N_LOG), .N_PHYS(N_PHYS), .N_RD(3)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (alloc),
    .wr_addr_i (dst_log_i),
    .wr_data_i (fl_head)
  );

  rn_free_list #(.N_LOG(N_LOG), .N_PHYS(N_PHYS)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (alloc),
    .push_i     (rel_valid_i),
    .push_tag_i (rel_phys_i),
    .head_tag_o (fl_head),
    .empty_o    (fl_empty),
    .count_o    (fl_count)
  );

  assign src0_phys_o = rd_data[0];
  assign src1_phys_o = rd_data[1];
  assign old_phys_o  = rd_data[2];
  assign dst_phys_o  = fl_head;
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int unsigned N_LOG  = rn_pkg::DEF_N_LOG,
  parameter int unsigned N_PHYS = rn_pkg::DEF_N_PHYS,
  localparam int unsigned LOG_W  = $clog2(N_LOG),
  localparam int unsigned PHYS_W = $clog2(N_PHYS),
  localparam int unsigned CNT_W  = $clog2(N_PHYS - N_LOG + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ren_valid_i,
  input logic              ren_ready_o,
  input logic [LOG_W-1:0]  src0_log_i,
  input logic              dst_en_i,
  input logic [LOG_W-1:0]  dst_log_i,
  input logic [PHYS_W-1:0] src0_phys_o,
  input logic [PHYS_W-1:0] dst_phys_o,
  input logic [PHYS_W-1:0] old_phys_o,
  input logic              rel_valid_i,
  input logic [CNT_W-1:0]  free_cnt
);
  logic fire;
  assign fire = ren_valid_i && ren_ready_o;

  p_map_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dst_en_i) |=> (src0_log_i != $past(dst_log_i)) || (src0_phys_o == $past(dst_phys_o)));

  p_src_pre_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dst_en_i && src0_log_i == dst_log_i) |-> src0_phys_o == old_phys_o);

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren_ready_o && !rel_valid_i) |=> !ren_ready_o);

  p_last_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dst_en_i && free_cnt == CNT_W'(1) && !rel_valid_i) |=> !ren_ready_o);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt <= CNT_W'(N_PHYS - N_LOG));

  p_nodst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !dst_en_i && !rel_valid_i) |=> $stable(free_cnt));

  p_fresh_tag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dst_en_i) |-> dst_phys_o != old_phys_o);

  p_balance_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dst_en_i && rel_valid_i) |=> $stable(free_cnt));
endmodule

bind reg_renamer rn_checker #(.N_LOG(N_LOG), .N_PHYS(N_PHYS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ren_valid_i (ren_valid_i),
  .ren_ready_o (ren_ready_o),
  .src0_log_i  (src0_log_i),
  .dst_en_i    (dst_en_i),
  .dst_log_i   (dst_log_i),
  .src0_phys_o (src0_phys_o),
  .dst_phys_o  (dst_phys_o),
  .old_phys_o  (old_phys_o),
  .rel_valid_i (rel_valid_i),
  .free_cnt    (fl_count)
);

// File: tb/reg_renamer_tb_top.sv
module reg_renamer_tb_top;
  localparam int NL = 8;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, dst_en = 1'b0, rel_valid = 1'b0;
  logic [2:0] src0 = '0, src1 = '0, dst = '0;
  logic [3:0] rel_tag = '0;
  logic ready;
  logic [3:0] s0p, s1p, dp, op;

  int n_chk = 0, n_fail = 0;
  int map_m [NL];
  int fl_m [$];
  int ret_m [$];
  int unsigned lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  reg_renamer #(.N_LOG(NL), .N_PHYS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ren_valid_i(ren_valid), .ren_ready_o(ready),
    .src0_log_i(src0), .src1_log_i(src1), .dst_en_i(dst_en), .dst_log_i(dst),
    .src0_phys_o(s0p), .src1_phys_o(s1p), .dst_phys_o(dp), .old_phys_o(op),
    .rel_valid_i(rel_valid), .rel_phys_i(rel_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'((lcg >> 16) % m);
  endfunction

  // drive at negedge, check 1 ns later, commit at posedge
  task automatic op_cycle(input bit v, input int a0, input int a1, input bit de, input int d,
                          input bit rv, input int rt, input string tag);
    bit exp_rdy;
    int old;
    ren_valid = v; src0 = 3'(a0); src1 = 3'(a1); dst_en = de; dst = 3'(d);
    rel_valid = rv; rel_tag = 4'(rt);
    #1;
    exp_rdy = (fl_m.size() != 0);
    chk("R2 ready", int'(ready), int'(exp_rdy));
    chk({tag, " src0"}, int'(s0p), map_m[a0]);
    chk({tag, " src1"}, int'(s1p), map_m[a1]);
    if (de) chk("R5 old tag", int'(op), map_m[d]);
    if (de && exp_rdy) chk({tag, " dst tag"}, int'(dp), fl_m[0]);
    if (v && de && exp_rdy) chk("R10 fresh", int'(dp != op), 1);
    @(posedge clk);
    if (v && de && exp_rdy) begin
      old = map_m[d];
      map_m[d] = fl_m.pop_front();
      ret_m.push_back(old);
    end
    if (rv) fl_m.push_back(rt);
    @(negedge clk);
    ren_valid = 1'b0; dst_en = 1'b0; rel_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) map_m[i] = i;
    for (int i = NL; i < NP; i++) fl_m.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset identity mapping
    for (int i = 0; i < NL; i++) op_cycle(0, i, (i + 1) % NL, 0, 0, 0, 0, "R1");

    // R3/R6: drain queue; source equals destination
    for (int k = 0; k < NP - NL; k++) op_cycle(1, k, 7 - k, 1, k, 0, 0, "R3 R6");
    chk("R2 empty stall", int'(ready), 0);

    // R7: requests while stalled change nothing
    for (int k = 0; k < 3; k++) op_cycle(1, k, k, 1, 7 - k, 0, 0, "R7");
    for (int i = 0; i < NL; i++) op_cycle(0, i, i, 0, 0, 0, 0, "R7");

    // R8: release in reverse retire order, then reallocate
    while (ret_m.size() != 0) op_cycle(0, 0, 0, 0, 0, 1, ret_m.pop_back(), "R8");
    for (int k = 0; k < 4; k++) op_cycle(1, k + 4, k, 1, k + 4, 0, 0, "R8");

    // R9: no-destination renames consume nothing
    for (int k = 0; k < 4; k++) op_cycle(1, k, k + 4, 0, k, 0, 0, "R9");
    op_cycle(1, 1, 2, 1, 3, 0, 0, "R9");

    // R11: allocate and release together
    for (int k = 0; k < 6; k++)
      op_cycle(1, k, 7 - k, 1, k % 2, ret_m.size() != 0, ret_m.size() != 0 ? ret_m.pop_front() : 0, "R11");

    // R4: mixed long run
    for (int c = 0; c < 3000; c++) begin
      bit rv = (ret_m.size() != 0) && (rnd(3) != 0);
      int rt = rv ? ret_m.pop_front() : 0;
      op_cycle(rnd(4) != 0, rnd(NL), rnd(NL), rnd(5) != 0, rnd(NL), rv, rt, "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule